// File: doc/BRIEF.md
# Packet Message Transmit Sequencer

This block turns a run of packets held in a dual-port RAM into one outgoing message on a single channel. Software places the packets back to back, writes the address of the first word and the address of the final word of the message, selects transmit mode and raises the start control. The sequencer then reads the RAM one word per clock and hands each word to the line stage. Each packet's own length field tells the sequencer where that packet ends. At every packet end it compares the absolute packet-end address with the programmed end-of-message address to decide whether another packet follows.

Each packet is laid out from relative address 0 as: command low half, command high half, offset, label, length, then `length` data words, then the CRC word. The overhead is six words, so the CRC, which is the last word, sits at relative address `length + 5`. Between messages, and whenever no RAM word is on the line, the channel either carries a fill pattern or is released (output enable low). The `idle_en` control selects between the two. A one-cycle event marks the end of any packet whose command requests it. A one-cycle clear request, which the software register uses to drop its start bit, marks the end of the message when clear-enable is set.

The state machine has three states. `S_IDLE` waits for a launch. `S_PRIME` issues the first RAM read of a message. `S_STREAM` receives one word per cycle and issues the next read. The transitions are: `S_IDLE -> S_PRIME` on a rising `start` while `tx_mode` is high. `S_PRIME -> S_STREAM` happens unconditionally. `S_STREAM -> S_STREAM` is taken at a packet end that is not the last one while `start` is still high. `S_STREAM -> S_IDLE` is taken at a packet end that matches `eom_addr`, or at any packet end once `start` has been dropped.

Top module: `txseq_msg_tx`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `tx_oe`, `busy`, `ram_rd`, `pkt_evt` and `start_clr` are all low.
- R2: A rising edge of `start` sampled while `tx_mode` is high begins a message at `msg_base`. The words leave on `tx_data` with `tx_oe` high and `tx_fill` low, one per cycle in ascending address order, with no gap inside the message.
- R3: A packet's last (CRC) word is at relative address L+5, where L is the low AW bits of the word at relative address 4. A packet with 8 data words therefore sends 14 words and ends at relative 0xD.
- R4: When a packet is not the last, the next packet's first word is the address right after the previous CRC. It follows on the line in the very next cycle.
- R5: A packet whose absolute end address equals `eom_addr` is the last one. No word after its CRC is sent, even if more packets follow in RAM.
- R6: With `clr_en` and `tx_mode` high, `start_clr` pulses for exactly one cycle, in the same cycle as the message's final CRC word on the line and never earlier. With `clr_en` low it never pulses.
- R7: `pkt_evt` pulses for one cycle, together with a packet's CRC word on the line, when bit IRQ_BIT of that packet's 32-bit command is set. The default IRQ_BIT is 31, which is bit 15 of the word at relative address 1.
- R8: With `tx_mode` and `idle_en` high, every cycle without a RAM word drives `tx_oe` high, `tx_fill` high and `tx_data` equal to IDLE_PAT (default 16'h7E7E).
- R9: When `tx_mode` or `idle_en` is low, every cycle without a RAM word has `tx_oe` low.
- R10: If `start` falls in the middle of a message, the packet being sent is completed through its CRC. The sequencer then returns to idle without sending further packets and without a `start_clr` pulse.
- R11: A `start` edge has no effect while `tx_mode` is low. A `start` held high after a message does not launch it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_mode | input | 1 | Channel is in transmit mode |
| start | input | 1 | Start control; its rising edge launches a message |
| idle_en | input | 1 | Fill the line with IDLE_PAT instead of releasing it |
| clr_en | input | 1 | Allow the end-of-message start clear request |
| msg_base | input | AW | Address of the first word of the message |
| eom_addr | input | AW | Absolute address of the message's final CRC word |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | AW | RAM read address |
| ram_rdata | input | DW | RAM read data, valid one cycle after the strobe |
| tx_data | output | DW | Word on the line |
| tx_oe | output | 1 | Line driver enable (low means released) |
| tx_fill | output | 1 | Line carries the fill pattern |
| pkt_evt | output | 1 | Per-packet completion event |
| start_clr | output | 1 | One-cycle request to clear the start bit |
| busy | output | 1 | A message is in progress |

## Verification
The message path is tried with a single 8-data-word packet, which pins the L+5 end arithmetic. A three-packet buffer with lengths 0, 3 and 2 and a fourth packet beyond the end shows back-to-back packet chaining and the stop at the programmed end. The same buffer with the end address on its first packet separates the end-of-message match from a stop caused by running out of packets. A start drop inside the second packet shows that the packet is finished and not cut short. Events and clear requests are located by the word count at which they appear, so a pulse one word early or late is caught. Quiet periods are run with fill on, fill off and receive mode, which tells fill from release.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_PRIME  = 2'd1,
        S_STREAM = 2'd2
    } seq_state_t;

    // relative slot of the length word
    localparam int LEN_SLOT = 4;
    // CRC slot = length + this offset
    localparam int END_OFS  = 5;

endpackage

// File: rtl/txseq_ptr.sv
module txseq_ptr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (adv) begin
            addr <= addr + AW'(1);
        end
    end

endmodule

// File: rtl/txseq_pktend.sv
module txseq_pktend #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_vld,
    input  logic [AW-1:0] rd_rel,
    input  logic [AW-1:0] len_word,
    input  logic [AW-1:0] pkt_base,
    input  logic [AW-1:0] eom_addr,
    output logic          crc_hit,
    output logic          is_last,
    output logic [AW-1:0] next_base
);

    localparam logic [AW-1:0] LEN_REL = AW'(txseq_pkg::LEN_SLOT);
    localparam logic [AW-1:0] END_REL = AW'(txseq_pkg::END_OFS);

    logic [AW-1:0] len_q;
    logic [AW-1:0] end_rel;
    logic [AW-1:0] end_abs;

    // capture the length as its word goes by
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (rd_vld && (rd_rel == LEN_REL)) begin
            len_q <= len_word;
        end
    end

    always_comb begin
        end_rel   = len_q + END_REL;
        end_abs   = pkt_base + end_rel;
        // len_q is only current once the length slot has passed
        crc_hit   = rd_vld && (rd_rel > LEN_REL) && (rd_rel == end_rel);
        is_last   = (end_abs == eom_addr);
        next_base = end_abs + AW'(1);
    end

endmodule

// File: rtl/txseq_line.sv
module txseq_line #(
    parameter int          DW       = 16,
    parameter logic [DW-1:0] IDLE_PAT = 16'h7E7E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_vld,
    input  logic [DW-1:0] word,
    input  logic          tx_mode,
    input  logic          idle_en,
    output logic [DW-1:0] tx_data,
    output logic          tx_oe,
    output logic          tx_fill
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_data <= '0;
            tx_oe   <= 1'b0;
            tx_fill <= 1'b0;
        end else if (word_vld) begin
            tx_data <= word;
            tx_oe   <= 1'b1;
            tx_fill <= 1'b0;
        end else if (tx_mode && idle_en) begin
            tx_data <= IDLE_PAT;
            tx_oe   <= 1'b1;
            tx_fill <= 1'b1;
        end else begin
            tx_data <= '0;
            tx_oe   <= 1'b0;
            tx_fill <= 1'b0;
        end
    end

endmodule

// File: rtl/txseq_msg_tx.sv
module txseq_msg_tx #(
    parameter int            AW       = 10,
    parameter int            DW       = 16,
    parameter int            IRQ_BIT  = 31,
    parameter logic [DW-1:0] IDLE_PAT = 16'h7E7E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_mode,
    input  logic          start,
    input  logic          idle_en,
    input  logic          clr_en,
    input  logic [AW-1:0] msg_base,
    input  logic [AW-1:0] eom_addr,
    output logic          ram_rd,
    output logic [AW-1:0] ram_addr,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] tx_data,
    output logic          tx_oe,
    output logic          tx_fill,
    output logic          pkt_evt,
    output logic          start_clr,
    output logic          busy
);

    import txseq_pkg::*;

    // command is two words; AW must not exceed DW
    localparam int            IRQ_WORD = IRQ_BIT / DW;
    localparam int            IRQ_POS  = IRQ_BIT % DW;
    localparam logic [AW-1:0] IRQ_REL  = AW'(IRQ_WORD);

    seq_state_t    state, nxt;
    logic          start_q;
    logic          rd_vld;
    logic [AW-1:0] rd_rel;
    logic [AW-1:0] pkt_base;
    logic          irq_q;
    logic          go;
    logic          stop;
    logic          crc_hit;
    logic          is_last;
    logic [AW-1:0] next_base;

    assign go     = tx_mode && start && !start_q;
    assign stop   = crc_hit && (is_last || !start);
    assign ram_rd = (state == S_PRIME) || (state == S_STREAM);
    assign busy   = (state != S_IDLE);

    txseq_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state == S_IDLE) && go),
        .load_val (msg_base),
        .adv      (ram_rd),
        .addr     (ram_addr)
    );

    txseq_pktend #(.AW(AW)) u_end (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_vld    (rd_vld),
        .rd_rel    (rd_rel),
        .len_word  (ram_rdata[AW-1:0]),
        .pkt_base  (pkt_base),
        .eom_addr  (eom_addr),
        .crc_hit   (crc_hit),
        .is_last   (is_last),
        .next_base (next_base)
    );

    txseq_line #(.DW(DW), .IDLE_PAT(IDLE_PAT)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (rd_vld),
        .word     (ram_rdata),
        .tx_mode  (tx_mode),
        .idle_en  (idle_en),
        .tx_data  (tx_data),
        .tx_oe    (tx_oe),
        .tx_fill  (tx_fill)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (go) nxt = S_PRIME;
            S_PRIME:  nxt = S_STREAM;
            S_STREAM: if (stop) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            rd_vld    <= 1'b0;
            rd_rel    <= '0;
            pkt_base  <= '0;
            irq_q     <= 1'b0;
            pkt_evt   <= 1'b0;
            start_clr <= 1'b0;
        end else begin
            start_q   <= start;
            pkt_evt   <= 1'b0;
            start_clr <= 1'b0;
            if (rd_vld && (rd_rel == IRQ_REL)) begin
                irq_q <= ram_rdata[IRQ_POS];
            end
            unique case (state)
                S_IDLE: begin
                    rd_vld <= 1'b0;
                    rd_rel <= '0;
                    if (go) pkt_base <= msg_base;
                end
                S_PRIME: begin
                    rd_vld <= 1'b1;
                    rd_rel <= '0;
                end
                S_STREAM: begin
                    if (crc_hit) begin
                        pkt_evt <= irq_q;
                        if (stop) begin
                            rd_vld    <= 1'b0;
                            start_clr <= is_last && clr_en && tx_mode;
                        end else begin
                            rd_rel   <= '0;
                            pkt_base <= next_base;
                        end
                    end else begin
                        rd_rel <= rd_rel + AW'(1);
                    end
                end
                default: rd_vld <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/txseq_msg_tx_chk.sv
module txseq_msg_tx_chk #(
    parameter int            DW       = 16,
    parameter logic [DW-1:0] IDLE_PAT = 16'h7E7E
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tx_mode,
    input logic                   idle_en,
    input logic                   clr_en,
    input txseq_pkg::seq_state_t  state,
    input logic                   rd_vld,
    input logic [DW-1:0]          tx_data,
    input logic                   tx_oe,
    input logic                   tx_fill,
    input logic                   pkt_evt,
    input logic                   start_clr
);

    import txseq_pkg::*;

    p_word_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> (tx_oe && !tx_fill));

    p_prime_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRIME) |=> (state == S_STREAM && rd_vld));

    p_clr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |-> ($past(clr_en) && state == S_IDLE));

    p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !start_clr);

    p_evt_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_evt |-> ($past(state) == S_STREAM));

    p_idle_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_vld && tx_mode && idle_en) |=>
            (tx_oe && tx_fill && tx_data == IDLE_PAT));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_vld && !(tx_mode && idle_en)) |=> !tx_oe);

    p_launch_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_IDLE && state == S_PRIME) |-> $past(tx_mode));

endmodule

bind txseq_msg_tx txseq_msg_tx_chk #(.DW(DW), .IDLE_PAT(IDLE_PAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_mode   (tx_mode),
    .idle_en   (idle_en),
    .clr_en    (clr_en),
    .state     (state),
    .rd_vld    (rd_vld),
    .tx_data   (tx_data),
    .tx_oe     (tx_oe),
    .tx_fill   (tx_fill),
    .pkt_evt   (pkt_evt),
    .start_clr (start_clr)
);

// File: tb/sim_txseq_msg_tx.sv
module sim_txseq_msg_tx;

    localparam int          AW   = 10;
    localparam int          DW   = 16;
    localparam logic [15:0] IDLE = 16'h7E7E;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_mode = 1'b0, start = 1'b0, idle_en = 1'b0, clr_en = 1'b0;
    logic [AW-1:0] msg_base = '0, eom_addr = '0;
    logic          ram_rd;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] tx_data;
    logic          tx_oe, tx_fill, pkt_evt, start_clr, busy;

    always #5 clk = ~clk;

    txseq_msg_tx #(.AW(AW), .DW(DW), .IRQ_BIT(31), .IDLE_PAT(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .start(start),
        .idle_en(idle_en), .clr_en(clr_en), .msg_base(msg_base),
        .eom_addr(eom_addr), .ram_rd(ram_rd), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .tx_data(tx_data), .tx_oe(tx_oe),
        .tx_fill(tx_fill), .pkt_evt(pkt_evt), .start_clr(start_clr),
        .busy(busy)
    );

    logic [15:0] mem [0:1023];
    always @(posedge clk) if (ram_rd) ram_rdata <= mem[ram_addr];

    // line monitor, sole writer of its counters
    int got [0:511];
    int wcyc [0:511];
    int evt_at [0:63];
    int wcnt = 0, evt_cnt = 0, clr_cnt = 0, clr_at = 0;
    int fill_cnt = 0, fill_bad = 0, rel_cnt = 0, cyc = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_oe && !tx_fill && wcnt < 512) begin
                got[wcnt]  = int'(tx_data);
                wcyc[wcnt] = cyc;
                wcnt++;
            end
            if (tx_fill) begin
                fill_cnt++;
                if (tx_data != IDLE) fill_bad++;
            end
            if (!tx_oe) rel_cnt++;
            if (pkt_evt && evt_cnt < 64) begin
                evt_at[evt_cnt] = wcnt;
                evt_cnt++;
            end
            if (start_clr) begin
                clr_at = wcnt;
                clr_cnt++;
            end
        end
        cyc++;
    end

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // packet writer: returns address after the CRC
    task automatic put_pkt(input int a, input int len, input bit irq,
                           input int seed, output int nxt);
        mem[a]   = 16'(16'hA000 + seed);
        mem[a+1] = irq ? 16'(16'h8000 + seed) : 16'(16'h0100 + seed);
        mem[a+2] = 16'(16'h0040 + seed);
        mem[a+3] = 16'(16'h00B0 + seed);
        mem[a+4] = 16'(len);
        for (int i = 0; i < len; i++) mem[a+5+i] = 16'(16'h1000 + seed*16 + i);
        mem[a+5+len] = 16'(16'hC3C3 ^ seed);
        nxt = a + 6 + len;
    endtask

    task automatic launch(input int base, input int eom, input int on_cyc,
                          input int tail);
        @(negedge clk);
        msg_base = AW'(base);
        eom_addr = AW'(eom);
        start    = 1'b1;
        repeat (on_cyc) @(negedge clk);
        start = 1'b0;
        repeat (tail) @(negedge clk);
    endtask

    task automatic expect_words(input string rq, input int bi, input int a,
                                input int n);
        chk(rq, wcnt - bi, n);
        for (int i = 0; i < n; i++) chk(rq, got[bi+i], int'(mem[a+i]));
        if (n > 0) chk({rq, " contiguous"}, wcyc[bi+n-1] - wcyc[bi], n - 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 oe", int'(tx_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 pulses", int'({ram_rd, pkt_evt, start_clr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after", int'({tx_oe, busy, ram_rd, pkt_evt, start_clr}), 0);
    endtask

    // one packet with 8 data words, end at relative 0xD
    task automatic t_single;
        int nx, bi, eb, cb, fb;
        tx_mode = 1'b1; idle_en = 1'b1; clr_en = 1'b1;
        put_pkt(32'h020, 8, 1'b1, 1, nx);
        repeat (3) @(negedge clk);
        bi = wcnt; eb = evt_cnt; cb = clr_cnt; fb = fill_cnt;
        launch(32'h020, 32'h02D, 40, 6);
        expect_words("R3 single", bi, 32'h020, 14);
        chk("R2 eom=base+0xD", nx - 1 - 32'h020, 32'h00D);
        chk("R6 clr count", clr_cnt - cb, 1);
        chk("R6 clr with last CRC", clr_at - bi, 14);
        chk("R7 evt count", evt_cnt - eb, 1);
        chk("R7 evt at CRC", evt_at[eb] - bi, 14);
        chk("R8 fill seen", int'(fill_cnt > fb), 1);
        chk("R8 fill value", fill_bad, 0);
        chk("R11 held start no relaunch", wcnt - bi, 14);
    endtask

    // three chained packets, a fourth beyond the end address
    task automatic t_multi;
        int nx, bi, eb, cb;
        clr_en = 1'b0;
        put_pkt(32'h100, 0, 1'b1, 2, nx);
        put_pkt(nx, 3, 1'b0, 3, nx);
        put_pkt(nx, 2, 1'b1, 4, nx);
        put_pkt(nx, 1, 1'b1, 5, nx);
        bi = wcnt; eb = evt_cnt; cb = clr_cnt;
        launch(32'h100, 32'h116, 40, 6);
        expect_words("R4 chain", bi, 32'h100, 23);
        chk("R5 stop at end", wcnt - bi, 23);
        chk("R7 evt count", evt_cnt - eb, 2);
        chk("R7 evt pkt1", evt_at[eb] - bi, 6);
        chk("R7 evt pkt3", evt_at[eb+1] - bi, 23);
        chk("R6 no clr when disabled", clr_cnt - cb, 0);
    endtask

    // end address on the first packet of the same buffer
    task automatic t_eom_first;
        int bi, cb;
        clr_en = 1'b1;
        bi = wcnt; cb = clr_cnt;
        launch(32'h100, 32'h105, 30, 6);
        expect_words("R5 first only", bi, 32'h100, 6);
        chk("R6 clr count", clr_cnt - cb, 1);
        chk("R6 clr at CRC", clr_at - bi, 6);
    endtask

    // start dropped inside the second packet
    task automatic t_midstop;
        int bi, cb, eb;
        bi = wcnt; cb = clr_cnt; eb = evt_cnt;
        launch(32'h100, 32'h116, 9, 20);
        expect_words("R10 finish packet", bi, 32'h100, 15);
        chk("R10 no clr", clr_cnt - cb, 0);
        chk("R10 evt only pkt1", evt_cnt - eb, 1);
        chk("R10 idle after", int'(busy), 0);
    endtask

    task automatic t_quiet;
        int rb, fb, bi;
        idle_en = 1'b0;
        @(negedge clk);
        rb = rel_cnt; fb = fill_cnt;
        repeat (5) @(negedge clk);
        chk("R9 released", rel_cnt - rb, 5);
        chk("R9 no fill", fill_cnt - fb, 0);
        tx_mode = 1'b0; idle_en = 1'b1;
        @(negedge clk);
        bi = wcnt; rb = rel_cnt;
        launch(32'h020, 32'h02D, 20, 4);
        chk("R11 rx start ignored", wcnt - bi, 0);
        chk("R9 rx released", rel_cnt - rb, 25);
        chk("R11 not busy", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_eom_first();
        t_midstop();
        t_quiet();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule